// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial slave engine and turns the data bytes of a write transaction into one page update of a byte array. The first data byte places itself at the word address supplied by the engine. Every later byte goes to the next slot of the same page, and the slot index wraps at the page boundary. The buffer records which slots were loaded. When the engine reports a bus stop, only those slots are copied into the array.

After a commit, a busy flag stays high for a parameterized number of clocks, which stands in for the nonvolatile programming time. While it is high, the block discards received bytes and stops, and it refuses to acknowledge a device-address match. This lets the engine's acknowledge polling see the end of the cycle. A write-protect input blocks the commit. The running address is exposed so that a later current-address read continues where the write left off. The array also has a combinational read port.

Top module: `page_write_buffer`

## Requirements
- R1: The page size is PAGE_BYTES (8 or 16). The low log2(PAGE_BYTES) bits of the address form the slot. After each accepted byte, `cur_addr` holds the next slot, wrapped inside the page, and the upper address bits stay those of the first byte's `word_addr`.
- R2: If more than PAGE_BYTES bytes arrive in one transaction, the later bytes overwrite the earlier ones in the same slots, and the committed page holds the last byte written to each slot.
- R3: Array locations whose slot received no byte in the transaction keep their previous contents after the commit. This applies inside the written page and everywhere else.
- R4: A stop after at least one accepted byte, with `wp` low, writes the page at that clock edge. `busy` is then high for exactly WR_CYCLES cycles, starting in the cycle after the stop.
- R5: A stop that arrives with no accepted byte since the last stop changes no array location and leaves `busy` low.
- R6: While `busy` is high, `byte_vld` and `stop_evt` are ignored, `cur_addr` does not change, and `dev_ack` stays low even when `dev_sel` is high. Once `busy` falls, `dev_sel` gives `dev_ack` high.
- R7: With `wp` high at the stop, the array is unchanged, `busy` stays low, and the loaded bytes are discarded.
- R8: After a commit, `cur_addr` equals the last written address plus one, wrapped within its page.
- R9: After reset, `busy` is low, `cur_addr` is 0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | One-cycle strobe: a data byte was received |
| word_addr | input | ADDR_W | Word address, taken with the first byte of a transaction |
| byte_data | input | 8 | Received data byte |
| stop_evt | input | 1 | One-cycle strobe: bus stop detected |
| wp | input | 1 | Write protect, high blocks the commit |
| dev_sel | input | 1 | Device address matched on the bus |
| dev_ack | output | 1 | Acknowledge for the device address |
| busy | output | 1 | Self-timed write cycle in progress |
| cur_addr | output | ADDR_W | Running word address |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data |

## Verification
The checker watches every cycle for four things. `busy` may rise only right after a stop. Its high time must equal WR_CYCLES, measured by a counter. A byte strobe during `busy` must leave `cur_addr` alone. A protected stop must never raise `busy`. Page wrap, overwrite order, preservation of unloaded slots and the contents after a blocked write all depend on array data. Only the bench's scenarios show these, by comparing the whole array with a reference model for a 16-byte and an 8-byte page instance.

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [7:0]        byte_data,
  input  logic              stop_evt,
  input  logic              wp,
  input  logic              dev_sel,
  output logic              dev_ack,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int OFF   = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [7:0]            mem  [DEPTH];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [ADDR_W-OFF-1:0] page;
  logic [OFF-1:0]        ptr;
  logic [CNT_W-1:0]      cnt;

  logic           take, first, stop_ok, commit;
  logic [OFF-1:0] slot;

  assign busy     = cnt != '0;
  assign take     = byte_vld & ~busy;
  assign first    = take & ~|mask;
  assign slot     = first ? word_addr[OFF-1:0] : ptr;
  assign stop_ok  = stop_evt & ~busy;
  assign commit   = stop_ok & |mask & ~wp;
  assign dev_ack  = dev_sel & ~busy;
  assign cur_addr = {page, ptr};
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      page <= '0;
      ptr  <= '0;
      cnt  <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else begin
      if (busy) cnt <= cnt - 1'b1;
      if (take) begin
        pbuf[slot] <= byte_data;
        mask[slot] <= 1'b1;
        ptr        <= slot + 1'b1;
        if (first) page <= word_addr[ADDR_W-1:OFF];
      end
      if (stop_ok) mask <= '0;
      if (commit) cnt <= CNT_W'(WR_CYCLES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (mask[i]) mem[{page, OFF'(i)}] <= pbuf[i];
    end
  end
endmodule

// File: rtl/page_write_buffer_chk.sv
module page_write_buffer_chk #(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 50000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              stop_evt,
  input logic              wp,
  input logic              busy,
  input logic [ADDR_W-1:0] cur_addr
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_len <= 0;
    else if (!busy) busy_len <= 0;
    else            busy_len <= busy_len + 1;
  end

  // R4
  busy_rise_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt) && !$past(wp));

  // R4
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == WR_CYCLES);

  // R6
  busy_ignores_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_vld) |=> $stable(cur_addr));

  // R7
  protect_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && wp && !busy) |=> !busy);
endmodule

bind page_write_buffer page_write_buffer_chk #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .stop_evt(stop_evt),
  .wp(wp), .busy(busy), .cur_addr(cur_addr));

// File: tb/test_page_write_buffer.sv
module test_page_write_buffer;
  localparam int WRC = 20;

  logic clk = 0, rst_n = 0;
  logic byte_vld = 0, stop_evt = 0, wp = 0, dev_sel = 0;
  logic [7:0] word_addr = 0, byte_data = 0, rd_addr = 0;
  logic dev_ack, busy, dev_ack8, busy8;
  logic [7:0] cur_addr, rd_data, cur_addr8, rd_data8;

  logic [7:0] ref16 [256];
  logic [7:0] ref8  [256];
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  page_write_buffer #(.ADDR_W(8), .PAGE_BYTES(16), .WR_CYCLES(WRC)) i_page_write_buffer (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .word_addr(word_addr),
    .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp), .dev_sel(dev_sel),
    .dev_ack(dev_ack), .busy(busy), .cur_addr(cur_addr), .rd_addr(rd_addr), .rd_data(rd_data));

  page_write_buffer #(.ADDR_W(8), .PAGE_BYTES(8), .WR_CYCLES(WRC)) i_page_write_buffer_p8 (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .word_addr(word_addr),
    .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp), .dev_sel(dev_sel),
    .dev_ack(dev_ack8), .busy(busy8), .cur_addr(cur_addr8), .rd_addr(rd_addr), .rd_data(rd_data8));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_arrays(input string req);
    int bad16 = 0, bad8 = 0;
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a);
      #1;
      if (rd_data  !== ref16[a]) bad16++;
      if (rd_data8 !== ref8[a])  bad8++;
    end
    check({req, " mismatches p16"}, bad16, 0);
    check({req, " mismatches p8"}, bad8, 0);
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
  endtask

  task automatic txn(input logic [7:0] a, input int n, input logic [7:0] seed, input bit prot);
    logic [7:0] p16, p8, d;
    p16 = a; p8 = a; wp = prot;
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 7);
      @(negedge clk); byte_vld = 1; word_addr = a; byte_data = d;
      if (!prot) begin ref16[p16] = d; ref8[p8] = d; end
      p16 = (p16 & 8'hF0) | ((p16 + 8'd1) & 8'h0F);
      p8  = (p8  & 8'hF8) | ((p8  + 8'd1) & 8'h07);
    end
    @(negedge clk); byte_vld = 0;
    check("R1/R8 cur_addr p16", cur_addr, p16);
    check("R1/R8 cur_addr p8", cur_addr8, p8);
    pulse_stop();
    wp = 0;
  endtask

  task automatic busy_len(input string req, input int exp);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(req, n, exp);
  endtask

  task automatic t_reset();
    check("R9 busy", busy, 0);
    check("R9 cur_addr", cur_addr, 0);
    cmp_arrays("R9 array zero");
  endtask

  task automatic t_partial();
    txn(8'h25, 3, 8'h11, 0);
    busy_len("R4 busy length", WRC);
    cmp_arrays("R3 partial page");
    check("R8 next addr", cur_addr, 8'h28);
  endtask

  task automatic t_wrap();
    txn(8'h3C, 20, 8'h40, 0);
    busy_len("R2 busy length", WRC);
    cmp_arrays("R2 overflow overwrite");
    check("R8 wrapped addr", cur_addr, 8'h30);
  endtask

  task automatic t_busy();
    txn(8'h61, 2, 8'h90, 0);
    @(negedge clk); dev_sel = 1; #1;
    check("R6 nack while busy", dev_ack, 0);
    dev_sel = 0;
    @(negedge clk); byte_vld = 1; word_addr = 8'hA0; byte_data = 8'hEE;
    @(negedge clk); byte_vld = 0;
    check("R6 addr held while busy", cur_addr, 8'h63);
    pulse_stop();
    while (busy) @(negedge clk);
    dev_sel = 1; #1;
    check("R6 ack after cycle", dev_ack, 1);
    dev_sel = 0;
    pulse_stop();
    check("R6 dropped byte no commit", busy, 0);
    cmp_arrays("R6 array after busy");
  endtask

  task automatic t_empty_stop();
    pulse_stop();
    repeat (3) @(negedge clk);
    check("R5 no busy", busy, 0);
    cmp_arrays("R5 array unchanged");
  endtask

  task automatic t_wp();
    txn(8'h50, 5, 8'h21, 1);
    check("R7 no busy", busy, 0);
    cmp_arrays("R7 array unchanged");
    pulse_stop();
    check("R7 bytes discarded", busy, 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin ref16[a] = 0; ref8[a] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_partial();
    t_wrap();
    t_busy();
    t_empty_stop();
    t_wp();
    txn(8'h0E, 3, 8'h77, 0);
    busy_len("R1 busy length", WRC);
    cmp_arrays("R1 page size variants");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule